// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Controller

This block sits at the tail of a single-precision floating-point pipeline. On each cycle in which the pipeline presents a finished operation, the block reads the exception events raised by the arithmetic, the per-operation hints that overflow, underflow or inexact results are possible, an operation-class tag, the sign of the unrounded result and the computed result. From these inputs it does two things. It updates a status register that holds a per-operation cause field, a sticky flag field, a trap-enable field and two mode bits. It then either raises one shared trap request or releases the result for write-back. When no trap is taken, the result may be replaced by an IEEE-754 default value.

A denormalized input operand is a hard error unless denormal flushing is selected. No enable bit can mask this error. The overflow, underflow and inexact traps fire when the operation is marked as able to produce the condition, even if the condition did not occur. For such a trap the cause field can be left all zero. Software reads and writes the status register through a one-cycle port.

Top module: `fpx_trap_ctrl`

Status register layout (32 bits; unlisted bits read 0 and ignore writes). Cause: bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero, bit4 invalid, bit5 error. Flags: bits 12:8 (inexact..invalid, same order). Enables: bits 20:16 (same order). Bit 24: round-to-zero mode (0 = round to nearest). Bit 25: denormal flush mode (0 = denormal input is an error).

## Requirements
- R1: After reset the status register reads 0 (round-to-nearest, denormal error mode), and trapReq, wbEn and wbData are 0.
- R2: On each valid operation every cause bit is loaded with 1 when its event occurred and 0 otherwise. The error cause (bit5) counts as an event only when bit 25 is 0 and an operand is denormal.
- R3: A sticky flag bit (bits 12:8) is set when its event occurs and otherwise keeps its value. Without a valid operation or a software write the status register does not change.
- R4: With bit 25 at 0, a denormal input raises a trap whatever the enable bits hold.
- R5: With the invalid enable (bit 20) set, a trap is raised when the operation class is matrix-transform (opClass = 2) or an invalid event occurred.
- R6: With the divide-by-zero enable (bit 19) set, a divide-by-zero event raises a trap.
- R7: With the overflow, underflow or inexact enable (bits 18, 17, 16) set, the matching "may" hint raises a trap even when no event occurred and the cause field stays 0.
- R8: trapReq and wbEn are registered and appear exactly one cycle after opValid. Exactly one of them is 1 for a valid operation, so a trap suppresses write-back. Both are 0 one cycle after a cycle without opValid.
- R9: A non-trapping operation with an invalid event writes the quiet NaN pattern (default 32'h7FC00000).
- R10: A non-trapping divide-by-zero writes an infinity {sign, 8'hFF, 23'h0} that carries the unrounded sign.
- R11: A non-trapping overflow writes a signed infinity in round-to-nearest mode. In round-to-zero mode it writes the signed largest normal {sign, 8'hFE, 23'h7FFFFF}.
- R12: Substitution priority is invalid, then divide-by-zero, then overflow. With none of these events the computed result passes through unchanged.
- R13: A software write is visible on csrRdata one cycle later, with unused bits reading 0. When it falls in the same cycle as a valid operation, the written value wins over the hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | A finished operation is present |
| opClass | input | 2 | Operation class: 0 arith, 1 divide, 2 matrix-transform, 3 other |
| evtDenorm | input | 1 | An input operand was denormal |
| evtInvalid | input | 1 | Invalid operation occurred |
| evtDivZero | input | 1 | Division by zero occurred |
| evtOverflow | input | 1 | Overflow occurred |
| evtUnderflow | input | 1 | Underflow occurred |
| evtInexact | input | 1 | Inexact result occurred |
| mayOverflow | input | 1 | Operation can overflow |
| mayUnderflow | input | 1 | Operation can underflow |
| mayInexact | input | 1 | Operation can be inexact |
| resSign | input | 1 | Sign of the unrounded result |
| resIn | input | 32 | Computed result |
| csrWe | input | 1 | Software write strobe |
| csrWdata | input | 32 | Software write data |
| csrRdata | output | 32 | Status register contents |
| trapReq | output | 1 | Shared trap request |
| wbEn | output | 1 | Destination write-enable |
| wbData | output | 32 | Result to write back |

## Verification
A software write to the status register can land in the same cycle as a hardware cause and flag update from a valid operation. The bench provokes this by asserting csrWe and opValid on one edge, with an invalid event pending. It then checks that the status register holds exactly the written value and not the event's bits. It also checks that the write-back output still reflects the operation, judged against the enables in force before the write. Default-value substitution and the trap decision also overlap on one operation. The bench presents several events at once and checks which default value wins and when the trap suppresses write-back.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int unsigned NUM_EVT  = 5;   // inexact, underflow, overflow, divzero, invalid
  localparam int unsigned NUM_MAY  = 3;   // inexact, underflow, overflow
  localparam int unsigned CAUSE_W  = NUM_EVT + 1;
  localparam int unsigned CSR_W    = 32;
  localparam int unsigned CAUSE_LSB = 0;
  localparam int unsigned FLAG_LSB  = 8;
  localparam int unsigned EN_LSB    = 16;
  localparam int unsigned RZ_BIT    = 24;
  localparam int unsigned DN_BIT    = 25;
  localparam int unsigned IDX_I = 0;
  localparam int unsigned IDX_U = 1;
  localparam int unsigned IDX_O = 2;
  localparam int unsigned IDX_Z = 3;
  localparam int unsigned IDX_V = 4;

  typedef enum logic [1:0] {
    CLS_ARITH  = 2'd0,
    CLS_DIVIDE = 2'd1,
    CLS_MATRIX = 2'd2,
    CLS_OTHER  = 2'd3
  } opClass_e;

  typedef enum logic [1:0] {
    SUB_PASS = 2'd0,
    SUB_QNAN = 2'd1,
    SUB_INF  = 2'd2,
    SUB_MAXN = 2'd3
  } subst_e;

  typedef struct packed {
    logic                 take;
    logic                 trap;
    subst_e               subst;
    logic [CAUSE_W-1:0]   cause;
    logic [NUM_EVT-1:0]   flagSet;
  } ctrlStrb_t;
endpackage

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
(
  input  logic               opValid,
  input  logic [1:0]         opClass,
  input  logic               evtDenorm,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_MAY-1:0] may,
  input  logic [NUM_EVT-1:0] enables,
  input  logic               modeRz,
  input  logic               modeDn,
  output ctrlStrb_t          strb
);
  logic               errEvt;
  logic [NUM_EVT-1:0] trapVec;
  subst_e             substSel;

  assign errEvt = evtDenorm && !modeDn;

  // possibility-based traps for inexact, underflow, overflow
  for (genvar gi = 0; gi < NUM_MAY; gi++) begin : g_mayTrap
    assign trapVec[gi] = enables[gi] && may[gi];
  end
  assign trapVec[IDX_Z] = enables[IDX_Z] && evt[IDX_Z];
  assign trapVec[IDX_V] = enables[IDX_V] &&
                          (evt[IDX_V] || (opClass == CLS_MATRIX));

  always_comb begin
    if (evt[IDX_V])      substSel = SUB_QNAN;
    else if (evt[IDX_Z]) substSel = SUB_INF;
    else if (evt[IDX_O]) substSel = modeRz ? SUB_MAXN : SUB_INF;
    else                 substSel = SUB_PASS;
  end

  always_comb begin
    strb.take    = opValid;
    strb.trap    = errEvt || (|trapVec);
    strb.subst   = substSel;
    strb.cause   = {errEvt, evt};
    strb.flagSet = evt;
  end
endmodule

// File: rtl/fpx_dpath.sv
module fpx_dpath
  import fpx_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned DATA_W = 1 + EXP_W + FRAC_W,
  parameter logic [DATA_W-1:0] QNAN = 32'h7FC0_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic               resSign,
  input  logic [DATA_W-1:0]  resIn,
  input  logic               csrWe,
  input  logic [CSR_W-1:0]   csrWdata,
  output logic [CSR_W-1:0]   csrRdata,
  output logic [NUM_EVT-1:0] enables,
  output logic               modeRz,
  output logic               modeDn,
  output logic               trapReq,
  output logic               wbEn,
  output logic [DATA_W-1:0]  wbData
);
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [EXP_W-1:0]  EXP_MAX  = {{(EXP_W-1){1'b1}}, 1'b0};
  localparam logic [FRAC_W-1:0] FRAC_ONES = '1;

  logic [CAUSE_W-1:0] causeQ;
  logic [NUM_EVT-1:0] flagQ;
  logic [NUM_EVT-1:0] enQ;
  logic               rzQ, dnQ;
  logic [DATA_W-1:0]  substVal;

  always_comb begin
    csrRdata = '0;
    csrRdata[CAUSE_LSB +: CAUSE_W] = causeQ;
    csrRdata[FLAG_LSB  +: NUM_EVT] = flagQ;
    csrRdata[EN_LSB    +: NUM_EVT] = enQ;
    csrRdata[RZ_BIT] = rzQ;
    csrRdata[DN_BIT] = dnQ;
  end

  assign enables = enQ;
  assign modeRz  = rzQ;
  assign modeDn  = dnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
      flagQ  <= '0;
      enQ    <= '0;
      rzQ    <= 1'b0;
      dnQ    <= 1'b0;
    end else if (csrWe) begin
      causeQ <= csrWdata[CAUSE_LSB +: CAUSE_W];
      flagQ  <= csrWdata[FLAG_LSB  +: NUM_EVT];
      enQ    <= csrWdata[EN_LSB    +: NUM_EVT];
      rzQ    <= csrWdata[RZ_BIT];
      dnQ    <= csrWdata[DN_BIT];
    end else if (strb.take) begin
      causeQ <= strb.cause;
      flagQ  <= flagQ | strb.flagSet;
    end
  end

  always_comb begin
    unique case (strb.subst)
      SUB_QNAN: substVal = QNAN;
      SUB_INF:  substVal = {resSign, EXP_ONES, {FRAC_W{1'b0}}};
      SUB_MAXN: substVal = {resSign, EXP_MAX, FRAC_ONES};
      default:  substVal = resIn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapReq <= 1'b0;
      wbEn    <= 1'b0;
      wbData  <= '0;
    end else begin
      trapReq <= strb.take && strb.trap;
      wbEn    <= strb.take && !strb.trap;
      if (strb.take) wbData <= substVal;
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(trapReq && wbEn));

  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$past(csrWe) |-> (($past(flagQ) & ~flagQ) == '0));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(csrWe) && !$past(strb.take)) |-> $stable(csrRdata));

  a_r13_sw_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(csrWe) |-> (csrRdata[FLAG_LSB +: NUM_EVT] ==
                      $past(csrWdata[FLAG_LSB +: NUM_EVT])));
endmodule

// File: rtl/fpx_trap_ctrl.sv
module fpx_trap_ctrl
  import fpx_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  parameter logic [31:0] QNAN   = 32'h7FC0_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [1:0]  opClass,
  input  logic        evtDenorm,
  input  logic        evtInvalid,
  input  logic        evtDivZero,
  input  logic        evtOverflow,
  input  logic        evtUnderflow,
  input  logic        evtInexact,
  input  logic        mayOverflow,
  input  logic        mayUnderflow,
  input  logic        mayInexact,
  input  logic        resSign,
  input  logic [31:0] resIn,
  input  logic        csrWe,
  input  logic [31:0] csrWdata,
  output logic [31:0] csrRdata,
  output logic        trapReq,
  output logic        wbEn,
  output logic [31:0] wbData
);
  ctrlStrb_t          strb;
  logic [NUM_EVT-1:0] enables;
  logic               modeRz, modeDn;
  logic [NUM_EVT-1:0] evtVec;
  logic [NUM_MAY-1:0] mayVec;

  assign evtVec = {evtInvalid, evtDivZero, evtOverflow, evtUnderflow, evtInexact};
  assign mayVec = {mayOverflow, mayUnderflow, mayInexact};

  fpx_ctrl u_ctrl (
    .opValid  (opValid),
    .opClass  (opClass),
    .evtDenorm(evtDenorm),
    .evt      (evtVec),
    .may      (mayVec),
    .enables  (enables),
    .modeRz   (modeRz),
    .modeDn   (modeDn),
    .strb     (strb)
  );

  fpx_dpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .QNAN(QNAN)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .resSign (resSign),
    .resIn   (resIn),
    .csrWe   (csrWe),
    .csrWdata(csrWdata),
    .csrRdata(csrRdata),
    .enables (enables),
    .modeRz  (modeRz),
    .modeDn  (modeDn),
    .trapReq (trapReq),
    .wbEn    (wbEn),
    .wbData  (wbData)
  );

  a_r4_error_unmaskable: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && evtDenorm && !csrRdata[DN_BIT]) |=> trapReq);

  a_r5_matrix_trap: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == CLS_MATRIX && csrRdata[EN_LSB + IDX_V]) |=> trapReq);

  a_r7_may_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && mayOverflow && csrRdata[EN_LSB + IDX_O]) |=> trapReq);

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (trapReq ^ wbEn));

  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!trapReq && !wbEn));
endmodule

// File: tb/tb_fpx_trap_ctrl.sv
module tb_fpx_trap_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opClass = 2'd0;
  logic        evtDenorm = 1'b0, evtInvalid = 1'b0, evtDivZero = 1'b0;
  logic        evtOverflow = 1'b0, evtUnderflow = 1'b0, evtInexact = 1'b0;
  logic        mayOverflow = 1'b0, mayUnderflow = 1'b0, mayInexact = 1'b0;
  logic        resSign = 1'b0;
  logic [31:0] resIn = '0;
  logic        csrWe = 1'b0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic        trapReq, wbEn;
  logic [31:0] wbData;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  fpx_trap_ctrl dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .evtDenorm(evtDenorm), .evtInvalid(evtInvalid), .evtDivZero(evtDivZero),
    .evtOverflow(evtOverflow), .evtUnderflow(evtUnderflow), .evtInexact(evtInexact),
    .mayOverflow(mayOverflow), .mayUnderflow(mayUnderflow), .mayInexact(mayInexact),
    .resSign(resSign), .resIn(resIn), .csrWe(csrWe), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .trapReq(trapReq), .wbEn(wbEn), .wbData(wbData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // evt = {denorm, invalid, divzero, overflow, underflow, inexact}; may = {O,U,I}
  task automatic setOp(input logic [5:0] evt, input logic [2:0] may,
                       input logic [1:0] cls, input logic sgn, input logic [31:0] res);
    opValid = 1'b1;
    {evtDenorm, evtInvalid, evtDivZero, evtOverflow, evtUnderflow, evtInexact} = evt;
    {mayOverflow, mayUnderflow, mayInexact} = may;
    opClass = cls; resSign = sgn; resIn = res;
  endtask

  task automatic clearIn();
    opValid = 1'b0; csrWe = 1'b0;
    {evtDenorm, evtInvalid, evtDivZero, evtOverflow, evtUnderflow, evtInexact} = '0;
    {mayOverflow, mayUnderflow, mayInexact} = '0;
  endtask

  task automatic doOp(input logic [5:0] evt, input logic [2:0] may,
                      input logic [1:0] cls, input logic sgn, input logic [31:0] res);
    @(negedge clk);
    setOp(evt, may, cls, sgn, res);
    @(negedge clk);
    clearIn();
  endtask

  task automatic csrWrite(input logic [31:0] d);
    @(negedge clk);
    csrWe = 1'b1; csrWdata = d;
    @(negedge clk);
    clearIn();
  endtask

  task automatic t_reset();
    check("R1 status", csrRdata, 32'h0);
    check("R1 trapReq", {31'd0, trapReq}, 32'd0);
    check("R1 wbEn", {31'd0, wbEn}, 32'd0);
    check("R1 wbData", wbData, 32'h0);
  endtask

  task automatic t_csrAccess();
    csrWrite(32'hFFFF_FFFF);
    check("R13 readback mask", csrRdata, 32'h031F_1F3F);
    csrWrite(32'h0);
    check("R13 clear", csrRdata, 32'h0);
  endtask

  task automatic t_passThrough();
    doOp(6'b000000, 3'b000, 2'd0, 1'b0, 32'h3F80_0000);
    check("R8 wbEn", {31'd0, wbEn}, 32'd1);
    check("R8 trapReq", {31'd0, trapReq}, 32'd0);
    check("R12 pass", wbData, 32'h3F80_0000);
    check("R2 cause empty", csrRdata, 32'h0);
  endtask

  task automatic t_causeSticky();
    doOp(6'b000101, 3'b101, 2'd0, 1'b1, 32'h1234_5678);
    check("R11 RN overflow", wbData, 32'hFF80_0000);
    check("R2 cause O|I", csrRdata, 32'h0000_0505);
    doOp(6'b000010, 3'b010, 2'd0, 1'b0, 32'h0000_0001);
    check("R3 flags sticky", csrRdata, 32'h0000_0702);
    check("R12 pass underflow", wbData, 32'h0000_0001);
    repeat (3) @(negedge clk);
    check("R3 idle hold", csrRdata, 32'h0000_0702);
    check("R8 idle no wb", {31'd0, wbEn}, 32'd0);
  endtask

  task automatic t_roundZero();
    csrWrite(32'h0100_0000);
    doOp(6'b000100, 3'b100, 2'd0, 1'b0, 32'h0);
    check("R11 RZ maxnorm", wbData, 32'h7F7F_FFFF);
    check("R3 flag O", csrRdata, 32'h0100_0404);
  endtask

  task automatic t_priority();
    csrWrite(32'h0);
    doOp(6'b011100, 3'b100, 2'd1, 1'b1, 32'h0);
    check("R9 R12 qnan first", wbData, 32'h7FC0_0000);
    doOp(6'b001100, 3'b100, 2'd1, 1'b1, 32'h0);
    check("R10 R12 signed inf", wbData, 32'hFF80_0000);
    doOp(6'b001000, 3'b000, 2'd1, 1'b0, 32'h0);
    check("R10 positive inf", wbData, 32'h7F80_0000);
  endtask

  task automatic t_errorTrap();
    csrWrite(32'h0);
    doOp(6'b100000, 3'b000, 2'd0, 1'b0, 32'h1);
    check("R4 trap", {31'd0, trapReq}, 32'd1);
    check("R4 wb suppressed", {31'd0, wbEn}, 32'd0);
    check("R2 error cause", csrRdata, 32'h0000_0020);
    csrWrite(32'h0200_0000);
    doOp(6'b100000, 3'b000, 2'd0, 1'b0, 32'h1);
    check("R2 flush no trap", {30'd0, trapReq, wbEn}, 32'd1);
    check("R2 flush no cause", csrRdata, 32'h0200_0000);
  endtask

  task automatic t_invalidTrap();
    csrWrite(32'h0010_0000);
    doOp(6'b000000, 3'b000, 2'd2, 1'b0, 32'h0);
    check("R5 matrix trap", {30'd0, trapReq, wbEn}, 32'd2);
    check("R5 matrix cause empty", csrRdata, 32'h0010_0000);
    doOp(6'b010000, 3'b000, 2'd0, 1'b0, 32'h0);
    check("R5 invalid trap", {30'd0, trapReq, wbEn}, 32'd2);
    check("R5 invalid cause", csrRdata, 32'h0010_1010);
    csrWrite(32'h0);
    doOp(6'b000000, 3'b000, 2'd2, 1'b0, 32'h4040_0000);
    check("R5 matrix disabled", {30'd0, trapReq, wbEn}, 32'd1);
  endtask

  task automatic t_divTrap();
    csrWrite(32'h0008_0000);
    doOp(6'b001000, 3'b000, 2'd1, 1'b0, 32'h0);
    check("R6 divzero trap", {30'd0, trapReq, wbEn}, 32'd2);
    doOp(6'b010000, 3'b000, 2'd1, 1'b0, 32'h0);
    check("R6 other event no trap", {30'd0, trapReq, wbEn}, 32'd1);
  endtask

  task automatic t_mayTrap();
    csrWrite(32'h0001_0000);
    doOp(6'b000000, 3'b001, 2'd0, 1'b0, 32'h0);
    check("R7 may inexact trap", {30'd0, trapReq, wbEn}, 32'd2);
    check("R7 cause empty", csrRdata, 32'h0001_0000);
    csrWrite(32'h0002_0000);
    doOp(6'b000000, 3'b010, 2'd0, 1'b0, 32'h0);
    check("R7 may underflow trap", {30'd0, trapReq, wbEn}, 32'd2);
    doOp(6'b000000, 3'b101, 2'd0, 1'b0, 32'h0);
    check("R7 other hints masked", {30'd0, trapReq, wbEn}, 32'd1);
    csrWrite(32'h0004_0000);
    doOp(6'b000000, 3'b100, 2'd0, 1'b0, 32'h0);
    check("R7 may overflow trap", {30'd0, trapReq, wbEn}, 32'd2);
  endtask

  task automatic t_swCollision();
    csrWrite(32'h0);
    @(negedge clk);
    setOp(6'b010000, 3'b000, 2'd0, 1'b0, 32'h0);
    csrWe = 1'b1; csrWdata = 32'h0010_0000;
    @(negedge clk);
    clearIn();
    check("R13 sw wins", csrRdata, 32'h0010_0000);
    check("R13 op uses old enables", {30'd0, trapReq, wbEn}, 32'd1);
    check("R9 qnan on collision", wbData, 32'h7FC0_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_csrAccess();
    t_passThrough();
    t_causeSticky();
    t_roundZero();
    t_priority();
    t_errorTrap();
    t_invalidTrap();
    t_divTrap();
    t_mayTrap();
    t_swCollision();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule